// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between the wakeup logic and the execution stage of an out-of-order core. Ready instructions arrive one per cycle, each tagged with a sequence number, an operation class, a squashed flag and a memory flag. Each class holds its own small ready queue, sorted so that the lowest sequence number is at the head. In every cycle the selector walks the classes in order of their head age, oldest first, and issues up to `ISSUE_W` instructions to the execute stage.

A class is served only when its functional unit can take work. Each class owns one unit, and some classes need no unit at all. Single-cycle work and pipelined units go straight to the execute output, and the unit is released one cycle later. An unpipelined multi-cycle unit produces a completion after its issue latency minus one cycles, releases the unit at that completion, and stays busy until then. A squashed head is thrown away without using issue bandwidth. A non-memory instruction frees its queue entry when it issues. A memory instruction keeps its entry, and the memory side frees it later.

The input is a valid/ready stream. `in_ready` depends only on whether the queue of the class named by `in_cls` is full, and a push is taken on a clock edge where both `in_valid` and `in_ready` are high. The issue port has no hold state. `exec_ready` is the downstream acceptance for the current cycle, and the issue slots are valid only in a cycle where it is high. A slot that is not accepted is not offered again later.

Top module: `oldest_first_issue`

## Requirements
- R1: Within one class, instructions leave in ascending sequence-number order, whatever order they arrived in.
- R2: Classes with a ready head are visited in ascending order of head sequence number, using an unsigned compare. When two heads are equal, the lower class index goes first. Slot 0 carries the first instruction issued.
- R3: At most `ISSUE_W` instructions issue per cycle. None issue while `exec_ready` is low. `issue_count` equals the number of valid slots.
- R4: A squashed head reached by the walk is popped and dropped. It takes no slot and does not count toward the width.
- R5: When a class needs a unit and that unit is unavailable, the class is skipped for the cycle, its bit in `fu_busy_evt` pulses, and the walk goes on to the next class.
- R6: An instruction of a class with no unit, or whose unit has operation latency 1, is marked `iss_now`=1. A used unit pulses `fu_release` in the next cycle.
- R7: When the operation latency is greater than 1 and the issue latency L is at least 2, `iss_now`=0. `done_valid` and `fu_release` for that class pulse L-1 cycles after issue, with `done_seq` set to the issued sequence number. The class cannot issue again before the cycle after that completion.
- R8: When the operation latency is greater than 1 and the issue latency is 1 (a pipelined unit), `iss_now`=1 and the unit is released in the next cycle.
- R9: `iss_free` is 1 for a non-memory instruction and 0 for a memory instruction.
- R10: `in_ready` is low while the queue of the addressed class is full. A push offered while `in_ready` is low is not stored.
- R11: A class issues or drops at most one instruction per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Ready-instruction push valid |
| in_ready | output | 1 | Queue of class `in_cls` has room |
| in_seq | input | SEQ_W | Sequence number of the push |
| in_cls | input | CLS_W | Operation class of the push |
| in_squash | input | 1 | Pushed instruction is squashed |
| in_mem | input | 1 | Pushed instruction is a memory access |
| fu_avail | input | NCLS | Per-class unit free this cycle |
| fu_needed | input | NCLS | Class uses a unit (0 means no unit) |
| op_lat | input | NCLS*LAT_W | Per-class operation latency |
| iss_lat | input | NCLS*LAT_W | Per-class issue latency (1 means pipelined) |
| exec_ready | input | 1 | Execute stage accepts this cycle |
| iss_valid | output | ISSUE_W | Slot carries an issued instruction |
| iss_seq | output | ISSUE_W*SEQ_W | Sequence number per slot |
| iss_cls | output | ISSUE_W*CLS_W | Class per slot |
| iss_now | output | ISSUE_W | Result goes to execute now (1) or via a later completion (0) |
| iss_free | output | ISSUE_W | Queue entry freed at issue |
| done_valid | output | NCLS | Multi-cycle completion per class |
| done_seq | output | NCLS*SEQ_W | Sequence number of the completion |
| fu_release | output | NCLS | Unit release request per class |
| fu_busy_evt | output | NCLS | Class skipped because its unit was busy |
| issue_count | output | CNT_W | Instructions issued this cycle |

## Verification
A broken sorted insert shows up as a slot whose sequence number is out of order on the next issue cycle of that class. A broken class ranking shows up at once, in the same cycle, as a wrong class in slot 0. If a squashed entry is left at a head, or the pop of a skipped class is lost, a stale or repeated sequence number appears in the following cycle. A wrong unit timer moves the `done_valid`/`fu_release` pulse away from the L-1 cycle point, or lets the class issue while its unit is still occupied. Every one of these faults is visible within at most issue-latency cycles of the instruction that causes it.

// File: rtl/iq_pkg.sv
package iq_pkg;
  // Oldest-first order: smaller sequence number wins, then lower class index.
  function automatic logic ahead_of(input logic [31:0] sa, input int ia,
                                    input logic [31:0] sb, input int ib);
    return (sa < sb) || ((sa == sb) && (ia < ib));
  endfunction
endpackage

// File: rtl/iq_class_queue.sv
module iq_class_queue #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic             push_sq,
  input  logic             push_mem,
  input  logic             pop_en,
  output logic             head_valid,
  output logic [SEQ_W-1:0] head_seq,
  output logic             head_sq,
  output logic             head_mem,
  output logic             full
);
  localparam int PW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]       vld_q, sq_q, mem_q;
  logic [DEPTH*SEQ_W-1:0] seq_q;
  logic [DEPTH-1:0]       a_v, a_sq, a_mem, b_v, b_sq, b_mem;
  logic [DEPTH*SEQ_W-1:0] a_seq, b_seq;
  logic [DEPTH-1:0]       n_v, n_sq, n_mem;
  logic [DEPTH*SEQ_W-1:0] n_seq;
  logic [PW-1:0]          pos;

  always_comb begin
    // remove head first, then place the newcomer behind every entry not younger
    a_v   = pop_en ? (vld_q >> 1) : vld_q;
    a_sq  = pop_en ? (sq_q  >> 1) : sq_q;
    a_mem = pop_en ? (mem_q >> 1) : mem_q;
    a_seq = pop_en ? (seq_q >> SEQ_W) : seq_q;
    b_v   = a_v   << 1;
    b_sq  = a_sq  << 1;
    b_mem = a_mem << 1;
    b_seq = a_seq << SEQ_W;
    pos = '0;
    for (int i = 0; i < DEPTH; i++)
      if (a_v[i] && (a_seq[i*SEQ_W +: SEQ_W] <= push_seq)) pos = pos + PW'(1);
    n_v = a_v; n_sq = a_sq; n_mem = a_mem; n_seq = a_seq;
    if (push_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (PW'(i) == pos) begin
          n_v[i] = 1'b1; n_sq[i] = push_sq; n_mem[i] = push_mem;
          n_seq[i*SEQ_W +: SEQ_W] = push_seq;
        end else if (PW'(i) > pos) begin
          n_v[i] = b_v[i]; n_sq[i] = b_sq[i]; n_mem[i] = b_mem[i];
          n_seq[i*SEQ_W +: SEQ_W] = b_seq[i*SEQ_W +: SEQ_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0; sq_q <= '0; mem_q <= '0; seq_q <= '0;
    end else begin
      vld_q <= n_v; sq_q <= n_sq; mem_q <= n_mem; seq_q <= n_seq;
    end
  end

  assign head_valid = vld_q[0];
  assign head_seq   = seq_q[SEQ_W-1:0];
  assign head_sq    = sq_q[0];
  assign head_mem   = mem_q[0];
  assign full       = vld_q[DEPTH-1];

  // R10: the top never pushes into a full queue
  a_r10_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !full);

  for (genvar i = 1; i < DEPTH; i++) begin : g_order
    // R1: stored entries stay in nondecreasing sequence order
    a_r1_sorted: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[i] |-> (seq_q[i*SEQ_W +: SEQ_W] >= seq_q[(i-1)*SEQ_W +: SEQ_W]));
  end
endmodule

// File: rtl/iq_select.sv
module iq_select #(
  parameter int NCLS    = 4,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 8,
  localparam int CLS_W  = $clog2(NCLS),
  localparam int CNT_W  = $clog2(ISSUE_W + 1)
) (
  input  logic [NCLS-1:0]          hv,
  input  logic [NCLS*SEQ_W-1:0]    hseq,
  input  logic [NCLS-1:0]          hsq,
  input  logic [NCLS-1:0]          unit_ok,
  input  logic                     can_go,
  output logic [NCLS-1:0]          pop,
  output logic [NCLS-1:0]          busy_evt,
  output logic [ISSUE_W-1:0]       slot_v,
  output logic [ISSUE_W*CLS_W-1:0] slot_cls,
  output logic [CNT_W-1:0]         n_issued
);
  int rank [NCLS];
  int used;

  always_comb begin
    pop = '0; busy_evt = '0; slot_v = '0; slot_cls = '0; used = 0;
    for (int c = 0; c < NCLS; c++) begin
      rank[c] = 0;
      for (int k = 0; k < NCLS; k++)
        if (k != c && hv[k] &&
            iq_pkg::ahead_of(32'(hseq[k*SEQ_W +: SEQ_W]), k,
                             32'(hseq[c*SEQ_W +: SEQ_W]), c))
          rank[c] = rank[c] + 1;
    end
    for (int r = 0; r < NCLS; r++) begin
      for (int c = 0; c < NCLS; c++) begin
        if (hv[c] && rank[c] == r && can_go && used < ISSUE_W) begin
          if (hsq[c]) begin
            pop[c] = 1'b1;
          end else if (unit_ok[c]) begin
            pop[c] = 1'b1;
            slot_v[used] = 1'b1;
            slot_cls[used*CLS_W +: CLS_W] = CLS_W'(c);
            used = used + 1;
          end else begin
            busy_evt[c] = 1'b1;
          end
        end
      end
    end
    n_issued = CNT_W'(used);
  end
endmodule

// File: rtl/iq_unit_timer.sv
module iq_unit_timer #(
  parameter int NCLS  = 4,
  parameter int LAT_W = 3,
  parameter int SEQ_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCLS-1:0]       start,
  input  logic [NCLS*LAT_W-1:0] start_lat,
  input  logic [NCLS*SEQ_W-1:0] start_seq,
  input  logic [NCLS-1:0]       quick_rel,
  output logic [NCLS-1:0]       unit_busy,
  output logic [NCLS-1:0]       done_v,
  output logic [NCLS*SEQ_W-1:0] done_seq,
  output logic [NCLS-1:0]       release_o
);
  for (genvar c = 0; c < NCLS; c++) begin : g_unit
    logic [LAT_W-1:0] tmr_q;
    logic [SEQ_W-1:0] seq_q;
    logic             rel_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tmr_q <= '0; seq_q <= '0; rel_q <= 1'b0;
      end else begin
        rel_q <= quick_rel[c];
        if (start[c]) begin
          tmr_q <= start_lat[c*LAT_W +: LAT_W] - LAT_W'(1);
          seq_q <= start_seq[c*SEQ_W +: SEQ_W];
        end else if (tmr_q != '0) begin
          tmr_q <= tmr_q - LAT_W'(1);
        end
      end
    end

    assign unit_busy[c] = (tmr_q != '0);
    assign done_v[c]    = (tmr_q == LAT_W'(1));
    assign done_seq[c*SEQ_W +: SEQ_W] = seq_q;
    assign release_o[c] = rel_q | done_v[c];

    // R7: an occupied unpipelined unit never takes a new operation
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_q != '0) |-> !start[c]);
  end
endmodule

// File: rtl/oldest_first_issue.sv
module oldest_first_issue #(
  parameter int NCLS    = 4,
  parameter int ISSUE_W = 2,
  parameter int DEPTH   = 4,
  parameter int SEQ_W   = 8,
  parameter int LAT_W   = 3,
  localparam int CLS_W  = $clog2(NCLS),
  localparam int CNT_W  = $clog2(ISSUE_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [SEQ_W-1:0]         in_seq,
  input  logic [CLS_W-1:0]         in_cls,
  input  logic                     in_squash,
  input  logic                     in_mem,
  input  logic [NCLS-1:0]          fu_avail,
  input  logic [NCLS-1:0]          fu_needed,
  input  logic [NCLS*LAT_W-1:0]    op_lat,
  input  logic [NCLS*LAT_W-1:0]    iss_lat,
  input  logic                     exec_ready,
  output logic [ISSUE_W-1:0]       iss_valid,
  output logic [ISSUE_W*SEQ_W-1:0] iss_seq,
  output logic [ISSUE_W*CLS_W-1:0] iss_cls,
  output logic [ISSUE_W-1:0]       iss_now,
  output logic [ISSUE_W-1:0]       iss_free,
  output logic [NCLS-1:0]          done_valid,
  output logic [NCLS*SEQ_W-1:0]    done_seq,
  output logic [NCLS-1:0]          fu_release,
  output logic [NCLS-1:0]          fu_busy_evt,
  output logic [CNT_W-1:0]         issue_count
);
  logic [NCLS-1:0]       push_en, pop, q_full, h_v, h_sq, h_mem;
  logic [NCLS*SEQ_W-1:0] h_seq;
  logic [NCLS-1:0]       imm, unit_ok, unit_busy, take, start, quick_rel;

  assign in_ready = !q_full[in_cls];

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign push_en[c] = in_valid && in_ready && (in_cls == CLS_W'(c));
    iq_class_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push_en(push_en[c]), .push_seq(in_seq), .push_sq(in_squash), .push_mem(in_mem),
      .pop_en(pop[c]),
      .head_valid(h_v[c]), .head_seq(h_seq[c*SEQ_W +: SEQ_W]),
      .head_sq(h_sq[c]), .head_mem(h_mem[c]), .full(q_full[c]));
  end

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      imm[c] = !fu_needed[c] || (op_lat[c*LAT_W +: LAT_W] == LAT_W'(1)) ||
               (iss_lat[c*LAT_W +: LAT_W] <= LAT_W'(1));
      unit_ok[c]   = !fu_needed[c] || (fu_avail[c] && !unit_busy[c]);
      take[c]      = pop[c] && !h_sq[c];
      start[c]     = take[c] && !imm[c];
      quick_rel[c] = take[c] && fu_needed[c] && imm[c];
    end
  end

  iq_select #(.NCLS(NCLS), .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W)) u_sel (
    .hv(h_v), .hseq(h_seq), .hsq(h_sq), .unit_ok(unit_ok), .can_go(exec_ready),
    .pop(pop), .busy_evt(fu_busy_evt), .slot_v(iss_valid), .slot_cls(iss_cls),
    .n_issued(issue_count));

  always_comb begin
    for (int i = 0; i < ISSUE_W; i++) begin
      iss_seq[i*SEQ_W +: SEQ_W] = h_seq[iss_cls[i*CLS_W +: CLS_W]*SEQ_W +: SEQ_W];
      iss_now[i]  = imm[iss_cls[i*CLS_W +: CLS_W]];
      iss_free[i] = !h_mem[iss_cls[i*CLS_W +: CLS_W]];
    end
  end

  iq_unit_timer #(.NCLS(NCLS), .LAT_W(LAT_W), .SEQ_W(SEQ_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .start_lat(iss_lat),
    .start_seq(h_seq), .quick_rel(quick_rel), .unit_busy(unit_busy),
    .done_v(done_valid), .done_seq(done_seq), .release_o(fu_release));

  // R3: nothing leaves while the execute stage refuses
  a_r3_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_ready |-> (iss_valid == '0));

  // R11: a class never pops twice in a cycle, so at most NCLS pops
  a_r11_pop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pop) <= $countones(h_v));
endmodule

// File: tb/oldest_first_issue_tb.sv
module oldest_first_issue_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_squash = 0, in_mem = 0, exec_ready = 0;
  logic [7:0] in_seq = '0;
  logic [1:0] in_cls = '0;
  logic [3:0] fu_avail = 4'hF, fu_needed = 4'b1110;
  logic [11:0] op_lat  = {3'd4, 3'd3, 3'd1, 3'd1};
  logic [11:0] iss_lat = {3'd1, 3'd3, 3'd1, 3'd1};
  logic in_ready;
  logic [1:0] iss_valid, iss_now, iss_free, issue_count;
  logic [15:0] iss_seq;
  logic [3:0] iss_cls;
  logic [3:0] done_valid, fu_release, fu_busy_evt;
  logic [31:0] done_seq;
  int vectors = 0, miscomp = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  oldest_first_issue u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int cls, input int seq, input bit sq, input bit mem);
    in_valid = 1; in_cls = 2'(cls); in_seq = 8'(seq); in_squash = sq; in_mem = mem;
    @(negedge clk);
    in_valid = 0; in_squash = 0; in_mem = 0;
  endtask

  task automatic slot(input string req, input int i, input int cls, input int seq);
    chk({req, " slot valid"}, iss_valid[i], 1);
    chk({req, " slot class"}, iss_cls[i*2 +: 2], cls);
    chk({req, " slot seq"}, iss_seq[i*8 +: 8], seq);
  endtask

  task automatic t_reset();
    chk("R10 reset in_ready", in_ready, 1);
    chk("R3 reset iss_valid", iss_valid, 0);
    chk("R7 reset done_valid", done_valid, 0);
    chk("R6 reset fu_release", fu_release, 0);
  endtask

  task automatic t_order();
    push(1, 10, 0, 0); push(0, 5, 0, 0); push(3, 7, 0, 0); push(1, 3, 0, 0);
    exec_ready = 1; #1;
    slot("R2", 0, 1, 3); slot("R2", 1, 0, 5);
    chk("R3 count at width", issue_count, 2);
    chk("R6 iss_now", iss_now, 2'b11);
    @(negedge clk); #1;
    slot("R11 one per class", 0, 3, 7); slot("R1", 1, 1, 10);
    chk("R8 pipelined now", iss_now[0], 1);
    chk("R6 release next cycle", fu_release, 4'b0010);
    @(negedge clk); #1;
    chk("R3 empty count", issue_count, 0);
    chk("R8 pipelined release", fu_release, 4'b1010);
    exec_ready = 0;
    @(negedge clk);
  endtask

  task automatic t_squash();
    push(0, 20, 1, 0); push(1, 21, 0, 0); push(3, 22, 0, 0);
    exec_ready = 1; #1;
    slot("R4", 0, 1, 21); slot("R4", 1, 3, 22);
    @(negedge clk); #1;
    chk("R4 squashed head gone", issue_count, 0);
    exec_ready = 0;
    @(negedge clk);
  endtask

  task automatic t_stall();
    push(0, 30, 0, 0);
    #1 chk("R3 stalled valid", iss_valid, 0);
    @(negedge clk); #1;
    chk("R3 stalled count", issue_count, 0);
    exec_ready = 1; #1;
    slot("R3 after stall", 0, 0, 30);
    @(negedge clk); exec_ready = 0;
    @(negedge clk);
  endtask

  task automatic t_busy();
    push(1, 40, 0, 0); push(0, 41, 0, 0);
    fu_avail = 4'b1101; exec_ready = 1; #1;
    slot("R5 skip busy", 0, 0, 41);
    chk("R5 count", issue_count, 1);
    chk("R5 busy event", fu_busy_evt, 4'b0010);
    @(negedge clk); fu_avail = 4'hF; #1;
    slot("R5 retry", 0, 1, 40);
    @(negedge clk); exec_ready = 0;
    @(negedge clk);
  endtask

  task automatic t_unpiped();
    push(2, 50, 0, 0); push(2, 51, 0, 0);
    exec_ready = 1; #1;
    slot("R7", 0, 2, 50);
    chk("R7 delayed", iss_now[0], 0);
    @(negedge clk); #1;
    chk("R7 no early done", done_valid, 0);
    chk("R7 no early release", fu_release[2], 0);
    chk("R7 unit held", issue_count, 0);
    chk("R7 busy event", fu_busy_evt[2], 1);
    @(negedge clk); #1;
    chk("R7 done", done_valid, 4'b0100);
    chk("R7 done seq", done_seq[16 +: 8], 50);
    chk("R7 release at done", fu_release[2], 1);
    chk("R7 held at done", issue_count, 0);
    @(negedge clk); #1;
    slot("R7 next op", 0, 2, 51);
    @(negedge clk); exec_ready = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_mem_tie();
    push(1, 60, 0, 1); push(0, 61, 0, 0);
    exec_ready = 1; #1;
    chk("R9 mem keeps entry", iss_free[0], 0);
    chk("R9 plain frees", iss_free[1], 1);
    @(negedge clk); exec_ready = 0;
    push(3, 70, 0, 0); push(1, 70, 0, 0);
    exec_ready = 1; #1;
    slot("R2 tie lower class", 0, 1, 70); slot("R2 tie", 1, 3, 70);
    @(negedge clk); exec_ready = 0;
    @(negedge clk);
  endtask

  task automatic t_full_sort();
    push(0, 80, 0, 0); push(0, 81, 0, 0); push(0, 82, 0, 0); push(0, 83, 0, 0);
    in_cls = 0; #1;
    chk("R10 full", in_ready, 0);
    in_cls = 1; #1;
    chk("R10 other class", in_ready, 1);
    push(0, 79, 0, 0);
    for (int k = 0; k < 4; k++) begin
      exec_ready = 1; #1;
      slot("R10 drain", 0, 0, 80 + k);
      @(negedge clk);
    end
    #1 chk("R10 rejected push absent", issue_count, 0);
    exec_ready = 0;
    push(1, 95, 0, 0); push(1, 92, 0, 0); push(1, 97, 0, 0);
    exec_ready = 1;
    #1 slot("R1 sorted", 0, 1, 92);
    @(negedge clk); #1 slot("R1 sorted", 0, 1, 95);
    @(negedge clk); #1 slot("R1 sorted", 0, 1, 97);
    @(negedge clk); exec_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    @(negedge clk);
    t_order();
    t_squash();
    t_stall();
    t_busy();
    t_unpiped();
    t_mem_tie();
    t_full_sort();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      vectors++; miscomp++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end
endmodule